// File: doc/BRIEF.md
# Serial Clock-Register Command Slave

This block sits between a four-wire serial bus and the register file of a real-time clock. A host selects the block by pulling chip select low and clocks in an instruction byte, then an address byte, then a stream of data bytes. The read instruction sends back consecutive registers for as long as the host keeps clocking. The write instruction turns each received data byte into a one-cycle strobe on a parallel register bus. The timekeeping and alarm logic behind that bus is outside this block.

All serial inputs are brought into the system clock domain by two-flop synchronizers, and edges of the serial clock are detected there. The register address advances by one for every data byte in either direction. Only the two clock-space instructions are served. Every other instruction byte, including those meant for non-volatile memory, identity, watchdog or RAM clearing, makes the block sit out the rest of the frame.

The data flow has no back-pressure. The serial host cannot be stalled, so a received byte is offered to the register file as a valid-only pulse. The register file must accept a write strobe in any cycle and must return read data combinationally for the current address.

Top module: `spirtc_slave`

## Requirements
- R1: Bus mode 0 with the most significant bit first. MOSI is sampled on the rising edge of SCK, and MISO changes only after a falling edge.
- R2: The first byte of a frame is the instruction. 0x13 selects a register read and 0x12 selects a register write.
- R3: The second byte of a frame loads the register address, which appears on reg_addr.
- R4: During a write frame, each complete data byte produces exactly one single-cycle reg_we pulse, with the byte on reg_wdata and its target on reg_addr. No pulse is issued before all 8 bits of the byte have arrived.
- R5: Consecutive write data bytes in one frame go to consecutive addresses, starting at the address byte.
- R6: During a read frame, MISO carries the register at the given address, then the registers at the following addresses, one byte per 8 SCK cycles.
- R7: The address wraps from 0xFF to 0x00 in both reads and writes.
- R8: Raising spi_cs_n aborts the frame. A partially received byte is dropped without a strobe, and the next frame starts again with an instruction byte.
- R9: An instruction byte other than 0x12 or 0x13 (for example 0x03, 0x02, 0x05, 0x54) causes the rest of the frame to be ignored. No reg_we is issued and MISO stays low.
- R10: After reset, reg_we is 0, spi_miso is 0 and reg_addr is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_miso | output | 1 | Serial data to host, low when not reading |
| reg_addr | output | AW | Register address toward clock logic |
| reg_wdata | output | DW | Write data toward clock logic |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | DW | Combinational read data for reg_addr |

## Verification
The assertions assume that each SCK level lasts at least six system clocks, so every serial edge is seen after synchronization and a byte completes long before the next one can. They also assume that spi_cs_n changes only while SCK is low. The stimulus holds each SCK half-period for eight system clocks, changes MOSI and chip select only while SCK is low, and keeps the frame-select gap several half-periods long. Under these limits the strobe, abort and increment properties can rely on byte events being widely spaced.

// File: rtl/spirtc_pkg.sv
package spirtc_pkg;
  localparam logic [7:0] OPC_READ  = 8'h13;
  localparam logic [7:0] OPC_WRITE = 8'h12;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADR,
    PH_RD,
    PH_WR,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spirtc_sync.sv
module spirtc_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q_out
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign q_out[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spirtc_shift.sv
module spirtc_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         mosi_s,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  output logic         byte_vld,
  output logic [W-1:0] byte_data,
  output logic         tx_bit
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] bitcnt;
  logic [W-1:0]  rx_sh;
  logic [W-1:0]  tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else if (clr) begin
      bitcnt   <= '0;
      tx_sh    <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (sck_rise) begin
        rx_sh  <= {rx_sh[W-2:0], mosi_s};
        bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + 1'b1;
        if (bitcnt == LAST) begin
          byte_vld  <= 1'b1;
          byte_data <= {rx_sh[W-2:0], mosi_s};
        end
      end
      if (sck_fall) begin
        if (bitcnt == '0 && ld_en) tx_sh <= ld_data;
        else                       tx_sh <= {tx_sh[W-2:0], 1'b0};
      end
    end
  end

  assign tx_bit = tx_sh[W-1];

  AST_CLR_DROPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !byte_vld); // R8
  AST_VLD_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(sck_rise)); // R1
endmodule

// File: rtl/spirtc_ctrl.sv
module spirtc_ctrl
  import spirtc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_data,
  output phase_t        phase,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we
);
  logic dir_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OPC;
      dir_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) reg_addr <= reg_addr + 1'b1;
      if (cs_s) begin
        phase <= PH_OPC;
      end else if (byte_vld) begin
        case (phase)
          PH_OPC: begin
            if (byte_data[7:0] == OPC_READ) begin
              dir_rd <= 1'b1;
              phase  <= PH_ADR;
            end else if (byte_data[7:0] == OPC_WRITE) begin
              dir_rd <= 1'b0;
              phase  <= PH_ADR;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_ADR: begin
            reg_addr <= AW'(byte_data);
            phase    <= dir_rd ? PH_RD : PH_WR;
          end
          PH_RD: reg_addr <= reg_addr + 1'b1;
          PH_WR: begin
            reg_we    <= 1'b1;
            reg_wdata <= byte_data;
          end
          default: ;
        endcase
      end
    end
  end

  AST_WE_AFTER_WR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ($past(byte_vld) && $past(phase) == PH_WR)); // R4
  AST_ABORT_TO_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> phase == PH_OPC); // R8
  AST_SKIP_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |=> !reg_we); // R9
endmodule

// File: rtl/spirtc_slave.sv
module spirtc_slave
  import spirtc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          spi_cs_n,
  output logic          spi_miso,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_we,
  input  logic [DW-1:0] reg_rdata
);
  logic [2:0]    sync_q;
  logic          sck_s, mosi_s, cs_s, sck_d;
  logic          sck_rise, sck_fall;
  logic          byte_vld, tx_bit;
  logic [DW-1:0] byte_data;
  phase_t        phase;

  spirtc_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({spi_cs_n, spi_mosi, spi_sck}),
    .q_out(sync_q)
  );
  assign sck_s  = sync_q[0];
  assign mosi_s = sync_q[1];
  assign cs_s   = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_d & ~cs_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_s;

  spirtc_shift #(.W(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(cs_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .ld_en(phase == PH_RD), .ld_data(reg_rdata),
    .byte_vld(byte_vld), .byte_data(byte_data), .tx_bit(tx_bit)
  );

  spirtc_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .phase(phase), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we)
  );

  assign spi_miso = (phase == PH_RD) & tx_bit;

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == $past(reg_addr) + 1'b1); // R5 R7
  AST_MISO_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_miso) |-> !sck_s); // R1
endmodule

// File: tb/sim_spirtc_slave.sv
`timescale 1ns/1ps
module sim_spirtc_slave;
  localparam int HP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic       miso, we;
  logic [7:0] addr, wdata, rdata;
  logic [7:0] mem [256];
  logic [15:0] expq [$];
  int         n_chk = 0, n_fail = 0, n_strobe = 0;
  bit         done = 1'b0;
  logic [7:0] wbuf [8];

  always #4 clk = ~clk;

  spirtc_slave u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_cs_n(cs_n), .spi_miso(miso), .reg_addr(addr),
    .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata)
  );

  assign rdata = mem[addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: owns the register model and pops the scoreboard on each strobe
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    end else if (we) begin
      n_strobe++;
      if (expq.size() == 0) begin
        chk(1'b0, "R4/R9 unexpected strobe", {addr, wdata}, 0);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk({addr, wdata} == e, "R4/R5/R7 strobe addr,data", {addr, wdata}, e);
      end
      mem[addr] = wdata;
    end
  end

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nbits; b--) begin
      mosi = tx[b];
      repeat (HP) @(negedge clk);
      rx[b] = miso;
      sck = 1'b1;
      repeat (HP) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HP) @(negedge clk);
  endtask

  // driver: write frame, pushes expected strobes (R2 R3 R4 R5 R7)
  task automatic wr_frame(input logic [7:0] a, input int n);
    logic [7:0] r;
    sel();
    xfer(8'h12, 8, r);
    xfer(a, 8, r);
    for (int k = 0; k < n; k++) begin
      expq.push_back({8'(a + k), wbuf[k]});
      xfer(wbuf[k], 8, r);
    end
    desel();
  endtask

  // read frame: compares MISO bytes with model (R1 R6 R7)
  task automatic rd_frame(input logic [7:0] a, input int n);
    logic [7:0] r, e;
    sel();
    xfer(8'h13, 8, r);
    xfer(a, 8, r);
    for (int k = 0; k < n; k++) begin
      e = mem[8'(a + k)];
      xfer(8'h00, 8, r);
      chk(r == e, "R6 read byte", r, e);
    end
    desel();
  endtask

  initial begin
    logic [7:0] r;
    int s0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miso == 1'b0, "R10 miso after reset", miso, 0);
    chk(we == 1'b0, "R10 strobe after reset", we, 0);
    chk(addr == 8'h00, "R10 addr after reset", addr, 0);

    rd_frame(8'h10, 3);                          // R6 burst read
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
    wr_frame(8'h20, 3);                          // R4 R5
    chk(expq.size() == 0, "R4 all strobes seen", expq.size(), 0);
    rd_frame(8'h1F, 5);                          // R6 readback of written data
    chk(addr == 8'h24, "R3 address advanced", addr, 8'h24);

    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_frame(8'hFE, 3);                          // R7 write wrap
    rd_frame(8'hFF, 2);                          // R7 read wrap

    // R8: abort mid byte, no strobe, register untouched
    s0 = n_strobe;
    sel();
    xfer(8'h12, 8, r); xfer(8'h40, 8, r); xfer(8'hFF, 4, r);
    desel();
    chk(n_strobe == s0, "R8 partial byte strobe count", n_strobe, s0);
    rd_frame(8'h40, 1);                          // R8 next frame decodes fresh

    // R9: unknown opcodes ignored, MISO low
    foreach (wbuf[i]) wbuf[i] = 8'(i);
    for (int t = 0; t < 2; t++) begin
      logic [7:0] op, acc;
      op = (t == 0) ? 8'h03 : 8'h54;
      s0 = n_strobe;
      acc = '0;
      sel();
      xfer(op, 8, r);
      xfer(8'h40, 8, r); acc |= r;
      xfer(8'hAA, 8, r); acc |= r;
      xfer(8'h55, 8, r); acc |= r;
      desel();
      chk(acc == 8'h00, "R9 miso low", acc, 0);
      chk(n_strobe == s0, "R9 no strobe", n_strobe, s0);
    end
    rd_frame(8'h40, 2);                          // R9 registers unchanged
    chk(expq.size() == 0, "R5 scoreboard drained", expq.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule